// File: doc/BRIEF.md
# Masked Pin Level Controller

This block drives a small group of square-wave output pins from one register per pin. Software-side logic updates the pins with a single command byte. The upper half of the byte says which pins take part in the update. The lower half gives the new static level for each of those pins. Pins that are not named in the byte keep whatever they were doing, so any subset of pins changes in the same clock edge.

A second write port loads a duty value for one pin at a time. A duty of zero parks the pin low and a duty equal to the full-scale period parks it high. Any value between the two puts the pin on a compare-based PWM source that shares one free-running period counter with the other pins. A duty value above the period is refused and flagged for one cycle.

Top module: `pin_level_ctrl`

## Requirements
- R1: While `rst_n` is low, every pin output is 0 and `duty_reject` is 0. Every pin leaves reset in the static-low state, and the period counter starts from 0.
- R2: When `cmd_valid` is high, bit NPINS+i of `cmd_byte` selects pin i and bit i gives its new static level (1 high, 0 low). With NPINS=4, enable bits 0x10, 0x20, 0x40 and 0x80 belong to pins 0 to 3. The new level appears on `pins_out` after the clock edge that accepts the command.
- R3: A pin whose enable bit is clear, or a pin with no write at all, keeps its previous behaviour. This covers a static level and PWM at its stored duty.
- R4: A duty write of exactly 0 puts the addressed pin at a constant 0. A duty write of exactly PERIOD puts it at a constant 1.
- R5: A duty write strictly between 0 and PERIOD puts the pin in PWM mode. The shared counter runs 0 to PERIOD-1 and wraps. The pin is 1 while the counter is below the duty value, so it is high for exactly `duty` cycles out of every PERIOD.
- R6: A duty write above PERIOD changes neither the mode nor the stored duty of any pin. It raises `duty_reject` for exactly the one cycle after the write.
- R7: A set-state command that selects a pin in PWM mode takes that pin out of PWM and gives it the commanded static level.
- R8: If a command and a duty write address the same pin in the same cycle, the command decides the pin's state and the duty write is discarded for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command byte is presented this cycle |
| cmd_byte | input | 2*NPINS | Upper half: pin select mask; lower half: static levels |
| duty_valid | input | 1 | Duty write is presented this cycle |
| duty_pin | input | PIN_W | Index of the pin receiving the duty value |
| duty_val | input | DUTY_W | Duty in counter ticks, legal range 0 to PERIOD |
| pins_out | output | NPINS | Output pin levels |
| duty_reject | output | 1 | One-cycle pulse after an out-of-range duty write |

## Verification
The bench builds the block with NPINS=4 and PERIOD=10, which gives a 4-bit duty field. At that size all 256 command bytes can be applied in sequence against a running model of the pin levels. For every pin, every encodable duty value from 0 to 15 is written. This covers both ends of the legal range, every PWM duty, and every rejected value. The high time is counted over a full period, so the PWM checks do not depend on the counter's phase. Directed cases then test leaving PWM through a command, same-cycle collisions, and a reset in the middle of a run.

// File: rtl/pin_level_ctrl.sv
module pin_level_ctrl #(
  parameter int NPINS  = 4,
  parameter int PERIOD = 200,
  localparam int DUTY_W = $clog2(PERIOD + 1),
  localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2*NPINS-1:0]   cmd_byte,
  input  logic                 duty_valid,
  input  logic [PIN_W-1:0]     duty_pin,
  input  logic [DUTY_W-1:0]    duty_val,
  output logic [NPINS-1:0]     pins_out,
  output logic                 duty_reject
);

  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(PERIOD);
  localparam logic [DUTY_W-1:0] LAST = DUTY_W'(PERIOD - 1);

  typedef enum logic [1:0] {M_LOW, M_HIGH, M_PWM} mode_t;

  mode_t             mode_q [NPINS];
  logic [DUTY_W-1:0] duty_q [NPINS];
  logic [DUTY_W-1:0] cnt_q;
  logic [NPINS-1:0]  pwm_on;
  logic              duty_ok;

  assign duty_ok = duty_val <= FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      duty_reject <= 1'b0;
    end else begin
      cnt_q       <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      duty_reject <= duty_valid && !duty_ok;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPINS; i++) begin
      if (!rst_n) begin
        mode_q[i] <= M_LOW;
        duty_q[i] <= '0;
      end else if (cmd_valid && cmd_byte[NPINS+i]) begin
        mode_q[i] <= cmd_byte[i] ? M_HIGH : M_LOW;
      end else if (duty_valid && duty_ok && duty_pin == PIN_W'(i)) begin
        duty_q[i] <= duty_val;
        if (duty_val == '0)      mode_q[i] <= M_LOW;
        else if (duty_val == FULL) mode_q[i] <= M_HIGH;
        else                     mode_q[i] <= M_PWM;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pwm_on[i] = mode_q[i] == M_PWM;
      case (mode_q[i])
        M_HIGH:  pins_out[i] = 1'b1;
        M_PWM:   pins_out[i] = cnt_q < duty_q[i];
        default: pins_out[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pin_level_ctrl_chk.sv
module pin_level_ctrl_chk #(
  parameter int NPINS  = 4,
  parameter int PERIOD = 200,
  localparam int DUTY_W = $clog2(PERIOD + 1),
  localparam int PIN_W  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [2*NPINS-1:0] cmd_byte,
  input logic               duty_valid,
  input logic [PIN_W-1:0]   duty_pin,
  input logic [DUTY_W-1:0]  duty_val,
  input logic [NPINS-1:0]   pins_out,
  input logic               duty_reject,
  input logic [NPINS-1:0]   pwm_on,
  input logic [DUTY_W-1:0]  cnt_q
);

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> (pins_out == '0 && !duty_reject && cnt_q == '0));

  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < DUTY_W'(PERIOD));

  a_r6_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    duty_valid && (duty_val > DUTY_W'(PERIOD)) |=> duty_reject);

  a_r6_no_false_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_valid |=> !duty_reject);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && !duty_valid |=> $stable(pwm_on) && $stable(pins_out & ~pwm_on));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r2_cmd_level: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_byte[NPINS+i] |=> pins_out[i] == $past(cmd_byte[i]));

    a_r7_cmd_exits_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_byte[NPINS+i] |=> !pwm_on[i]);

    a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      duty_valid && duty_pin == PIN_W'(i) && duty_val == '0 &&
      !(cmd_valid && cmd_byte[NPINS+i]) |=> !pins_out[i] && !pwm_on[i]);

    a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      duty_valid && duty_pin == PIN_W'(i) && duty_val == DUTY_W'(PERIOD) &&
      !(cmd_valid && cmd_byte[NPINS+i]) |=> pins_out[i] && !pwm_on[i]);

    a_r5_pwm_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_on[i] && cnt_q == '0 |-> pins_out[i]);
  end

endmodule

bind pin_level_ctrl pin_level_ctrl_chk #(.NPINS(NPINS), .PERIOD(PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .duty_valid (duty_valid),
  .duty_pin   (duty_pin),
  .duty_val   (duty_val),
  .pins_out   (pins_out),
  .duty_reject(duty_reject),
  .pwm_on     (pwm_on),
  .cnt_q      (cnt_q)
);

// File: tb/pin_level_ctrl_test.sv
module pin_level_ctrl_test;
  localparam int NP  = 4;
  localparam int PER = 10;
  localparam int DW  = $clog2(PER + 1);
  localparam int PW  = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2*NP-1:0] cmd_byte = '0;
  logic          duty_valid = 1'b0;
  logic [PW-1:0] duty_pin = '0;
  logic [DW-1:0] duty_val = '0;
  logic [NP-1:0] pins_out;
  logic          duty_reject;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_level_ctrl #(.NPINS(NP), .PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .duty_valid(duty_valid), .duty_pin(duty_pin), .duty_val(duty_val),
    .pins_out(pins_out), .duty_reject(duty_reject)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2*NP-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_duty(input int p, input int v);
    @(negedge clk);
    duty_valid = 1'b1; duty_pin = PW'(p); duty_val = DW'(v);
    @(negedge clk);
    duty_valid = 1'b0;
  endtask

  task automatic do_both(input logic [2*NP-1:0] b, input int p, input int v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    duty_valid = 1'b1; duty_pin = PW'(p); duty_val = DW'(v);
    @(negedge clk);
    cmd_valid = 1'b0; duty_valid = 1'b0;
  endtask

  task automatic highs(input int p, output int h);
    h = 0;
    for (int k = 0; k < PER; k++) begin
      if (pins_out[p]) h++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] lv;
    int h;
    int prev;

    repeat (3) @(negedge clk);
    chk(pins_out == '0, "R1 reset pins", int'(pins_out), 0);
    chk(duty_reject == 1'b0, "R1 reset reject", int'(duty_reject), 0);
    rst_n = 1'b1;

    lv = '0;
    for (int b = 0; b < 256; b++) begin
      do_cmd(8'(b));
      for (int i = 0; i < NP; i++)
        if (b[NP+i]) lv[i] = b[i];
      chk(pins_out == lv, "R2 R3 command sweep", int'(pins_out), int'(lv));
    end
    repeat (4) @(negedge clk);
    chk(pins_out == lv, "R3 idle hold", int'(pins_out), int'(lv));

    for (int p = 0; p < NP; p++) begin
      do_cmd(8'(8'h10 << p));
      prev = 0;
      for (int v = 0; v < 16; v++) begin
        do_duty(p, v);
        if (v > PER) begin
          chk(duty_reject == 1'b1, "R6 reject pulse", int'(duty_reject), 1);
        end else begin
          chk(duty_reject == 1'b0, "R6 no reject", int'(duty_reject), 0);
          prev = v;
        end
        highs(p, h);
        if (v > PER)                chk(h == prev, "R6 state kept", h, prev);
        else if (v == 0 || v == PER) chk(h == prev, "R4 static end", h, prev);
        else                        chk(h == prev, "R5 pwm high time", h, prev);
        chk(duty_reject == 1'b0, "R6 single pulse", int'(duty_reject), 0);
      end
    end

    do_duty(0, 4);
    do_duty(1, 3);
    do_cmd(8'h11);
    highs(0, h);
    chk(h == PER, "R7 pwm to high", h, PER);
    highs(1, h);
    chk(h == 3, "R3 pwm untouched", h, 3);
    do_cmd(8'h10);
    highs(0, h);
    chk(h == 0, "R7 to low", h, 0);

    do_cmd(8'h80);
    do_both(8'h88, 3, 5);
    highs(3, h);
    chk(h == PER, "R8 cmd wins high", h, PER);
    do_both(8'h80, 3, 5);
    highs(3, h);
    chk(h == 0, "R8 cmd wins low", h, 0);

    do_cmd(8'hFF);
    chk(pins_out == '1, "R2 all high", int'(pins_out), 15);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pins_out == '0, "R1 mid-run reset", int'(pins_out), 0);
    rst_n = 1'b1;
    highs(1, h);
    chk(h == 0, "R1 pwm cleared", h, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule